// File: doc/BRIEF.md
# Masked Wavefront Inclusive Scan Sequencer

This block computes an inclusive prefix scan over a 64-lane vector of unsigned values, using addition, minimum or maximum as the operator. A lane mask marks which lanes take part. Lane k of the result is the combination of every active lane from 0 up to k. Inactive lanes do not affect their active neighbours, and their result slots give back the value they were loaded with.

A one-cycle start pulse captures the vector, the mask and the operator. When the job is accepted, every inactive lane's working value is replaced by the operator's identity. The identity is 0 for add and for max, and all ones for min. All lanes then take part in seven combining steps:
- Steps 1 to 3 add in the loaded vector shifted right by 1, 2 and 3 lanes inside each 16-lane row.
- Step 4 combines the working vector shifted by 4, only in 4-lane banks 1 to 3 of each row.
- Step 5 combines the working vector shifted by 8, only in banks 2 and 3.
- Step 6 adds the last lane of the row below into rows 1 and 3.
- Step 7 adds lane 31 into rows 2 and 3.

Steps 4 to 7 each wait two idle cycles after the previous step, so the working register is never read in the cycle after it was written. When step 7 completes, the mask is applied again, the result is registered and `done_o` pulses once.

The controller has three states:
- ST_IDLE: waiting. It goes to ST_STEP on start.
- ST_STEP: one step is applied per cycle. After step 7 it goes to ST_IDLE. After steps 3 to 6 it goes to ST_GAP. After steps 1 and 2 it stays in ST_STEP.
- ST_GAP: two idle cycles, then back to ST_STEP.

Top module: `mscan_seq`

## Requirements
- R1: With `op_i` = 0 (add), and also with code 3, which is treated as add, every active lane k of `result_o` equals the sum modulo 2^DW of the inputs of all active lanes 0..k.
- R2: With `op_i` = 1 (min), every active lane k holds the unsigned minimum of the inputs of the active lanes 0..k.
- R3: With `op_i` = 2 (max), every active lane k holds the unsigned maximum of the inputs of the active lanes 0..k.
- R4: An inactive lane (bit of `exec_i` = 0) contributes nothing to any active lane's result, for any mask including sparse masks, masks that cross a row boundary and single-lane masks.
- R5: Every inactive lane's slot of `result_o` holds that lane's input value from the accepted start.
- R6: `done_o` rises exactly 15 clock edges after the edge that accepts start. Each of steps 4 to 7 is preceded by two cycles in which the working vector does not change.
- R7: `done_o` is high for exactly one cycle per accepted start. `busy_o` is high from the cycle after acceptance until `done_o` rises, and low while `done_o` is high.
- R8: A start pulse while `busy_o` is high is ignored: the running job's result is unchanged, and no extra `done_o` follows.
- R9: After reset, `busy_o` and `done_o` are 0 and `result_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| op_i | input | 2 | Operator: 0 add, 1 min, 2 max, 3 add |
| exec_i | input | 64 | Active-lane mask, bit k for lane k |
| data_i | input | 64*DW | Input vector, lane k in bits [k*DW +: DW] |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |
| result_o | output | 64*DW | Scanned vector, lane k in bits [k*DW +: DW] |

## Verification
Assertions check on every cycle the controller properties:
- each gap lasts exactly two cycles and then returns to a step;
- the step index stays in range;
- the working vector and the latched operator stay still while they should;
- `done_o` is a lone pulse that never overlaps `busy_o`.

Only the bench's scenarios can show that the row shifts, bank masks and broadcasts produce a correct prefix for every lane. They run each operator against full, empty, alternating, row-edge, single-lane and random masks, with expected results worked out directly as a running combination. The fixed 15-edge latency and the rejection of a start during a run are also checked by scenario.

// File: rtl/mscan_pkg.sv
package mscan_pkg;
    localparam int LANES      = 64;
    localparam int ROW_LANES  = 16;
    localparam int BANK_LANES = 4;
    localparam int NUM_ROWS   = LANES / ROW_LANES;
    localparam int NUM_BANKS  = ROW_LANES / BANK_LANES;

    typedef enum logic [1:0] {
        OP_ADD     = 2'd0,
        OP_MIN     = 2'd1,
        OP_MAX     = 2'd2,
        OP_ADD_ALT = 2'd3
    } scan_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_GAP  = 2'd2
    } ctrl_state_e;

    // step numbering and hazard spacing
    localparam logic [2:0] STEP_FIRST    = 3'd1;
    localparam logic [2:0] STEP_GAP_FROM = 3'd3;   // steps after this one are spaced
    localparam logic [2:0] STEP_LAST     = 3'd7;
    localparam int         GAP_CYCLES    = 2;
    localparam int         GAP_W         = 1;

    // lane enables of the spaced steps
    localparam logic [NUM_BANKS-1:0] SHIFT4_BANKS = 4'hE;
    localparam logic [NUM_BANKS-1:0] SHIFT8_BANKS = 4'hC;
    localparam logic [NUM_ROWS-1:0]  BCAST_ROWS_A = 4'hA;
    localparam logic [NUM_ROWS-1:0]  BCAST_ROWS_B = 4'hC;
endpackage

// File: rtl/mscan_fill.sv
module mscan_fill
    import mscan_pkg::*;
#(
    parameter int DW = 16
) (
    input  scan_op_e                   op_i,
    input  logic [LANES-1:0]           exec_i,
    input  logic [LANES-1:0][DW-1:0]   data_i,
    output logic [LANES-1:0][DW-1:0]   fill_o
);
    logic [DW-1:0] ident;

    always_comb begin
        unique case (op_i)
            OP_MIN:  ident = '1;
            default: ident = '0;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign fill_o[l] = exec_i[l] ? data_i[l] : ident;
    end
endmodule

// File: rtl/mscan_xchg.sv
module mscan_xchg
    import mscan_pkg::*;
#(
    parameter int DW = 16
) (
    input  scan_op_e                   op_i,
    input  logic [2:0]                 step_i,
    input  logic [LANES-1:0][DW-1:0]   work_i,
    input  logic [LANES-1:0][DW-1:0]   orig_i,
    output logic [LANES-1:0][DW-1:0]   next_o
);
    function automatic logic [DW-1:0] comb2(scan_op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
        unique case (op)
            OP_MIN:  comb2 = (a < b) ? a : b;
            OP_MAX:  comb2 = (a > b) ? a : b;
            default: comb2 = a + b;
        endcase
    endfunction

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int POS  = l % ROW_LANES;
        localparam int BANK = POS / BANK_LANES;
        localparam int ROW  = l / ROW_LANES;
        localparam int SRC1 = (POS >= 1) ? l - 1 : l;
        localparam int SRC2 = (POS >= 2) ? l - 2 : l;
        localparam int SRC3 = (POS >= 3) ? l - 3 : l;
        localparam int SRC4 = (POS >= 4) ? l - 4 : l;
        localparam int SRC8 = (POS >= 8) ? l - 8 : l;
        localparam int SRCR = (ROW >= 1) ? ROW * ROW_LANES - 1 : l;
        localparam int SRCB = 2 * ROW_LANES - 1;
        localparam bit EN4  = SHIFT4_BANKS[BANK] && (POS >= 4);
        localparam bit EN8  = SHIFT8_BANKS[BANK] && (POS >= 8);
        localparam bit ENR  = BCAST_ROWS_A[ROW] && (ROW >= 1);
        localparam bit ENB  = BCAST_ROWS_B[ROW] && (ROW >= 2);

        always_comb begin
            next_o[l] = work_i[l];
            case (step_i)
                3'd1: if (POS >= 1) next_o[l] = comb2(op_i, orig_i[SRC1], work_i[l]);
                3'd2: if (POS >= 2) next_o[l] = comb2(op_i, orig_i[SRC2], work_i[l]);
                3'd3: if (POS >= 3) next_o[l] = comb2(op_i, orig_i[SRC3], work_i[l]);
                3'd4: if (EN4)      next_o[l] = comb2(op_i, work_i[SRC4], work_i[l]);
                3'd5: if (EN8)      next_o[l] = comb2(op_i, work_i[SRC8], work_i[l]);
                3'd6: if (ENR)      next_o[l] = comb2(op_i, work_i[SRCR], work_i[l]);
                3'd7: if (ENB)      next_o[l] = comb2(op_i, work_i[SRCB], work_i[l]);
                default: next_o[l] = work_i[l];
            endcase
        end
    end
endmodule

// File: rtl/mscan_ctrl.sv
module mscan_ctrl
    import mscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       busy_o,
    output logic       load_o,
    output logic       step_en_o,
    output logic [2:0] step_o,
    output logic       last_o
);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

    ctrl_state_e      state_q, state_d;
    logic [2:0]       step_q;
    logic [GAP_W-1:0] gap_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_STEP;
            ST_STEP: begin
                if (step_q == STEP_LAST)          state_d = ST_IDLE;
                else if (step_q >= STEP_GAP_FROM) state_d = ST_GAP;
            end
            ST_GAP:  if (gap_q == GAP_LAST) state_d = ST_STEP;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= STEP_FIRST;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i)
                step_q <= STEP_FIRST;
            else if (state_q == ST_STEP && step_q != STEP_LAST)
                step_q <= step_q + 3'd1;
            if (state_q == ST_GAP) gap_q <= gap_q + 1'b1;
            else                   gap_q <= '0;
        end
    end

    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        load_o    = (state_q == ST_IDLE) && start_i;
        step_en_o = (state_q == ST_STEP);
        step_o    = step_q;
        last_o    = (state_q == ST_STEP) && (step_q == STEP_LAST);
    end

    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && gap_q != GAP_LAST) |=> (state_q == ST_GAP)); // R6
    AST_GAP_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && gap_q == GAP_LAST) |=> (state_q == ST_STEP)); // R6
    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (step_q >= STEP_FIRST && step_q <= STEP_LAST)); // R6
endmodule

// File: rtl/mscan_seq.sv
module mscan_seq
    import mscan_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          op_i,
    input  logic [LANES-1:0]    exec_i,
    input  logic [LANES*DW-1:0] data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [LANES*DW-1:0] result_o
);
    logic [LANES-1:0][DW-1:0] din, filled, work_q, orig_q, raw_q, nxt, res_q;
    logic [LANES-1:0]         exec_q;
    scan_op_e                 op_q, op_in;
    logic                     load, step_en, last;
    logic [2:0]               step;

    assign din   = data_i;
    assign op_in = scan_op_e'(op_i);

    mscan_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .busy_o    (busy_o),
        .load_o    (load),
        .step_en_o (step_en),
        .step_o    (step),
        .last_o    (last)
    );

    mscan_fill #(.DW(DW)) u_fill (
        .op_i   (op_in),
        .exec_i (exec_i),
        .data_i (din),
        .fill_o (filled)
    );

    mscan_xchg #(.DW(DW)) u_xchg (
        .op_i   (op_q),
        .step_i (step),
        .work_i (work_q),
        .orig_i (orig_q),
        .next_o (nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_ADD;
            exec_q <= '0;
            work_q <= '0;
            orig_q <= '0;
            raw_q  <= '0;
            res_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last;
            if (load) begin
                op_q   <= op_in;
                exec_q <= exec_i;
                work_q <= filled;
                orig_q <= filled;
                raw_q  <= din;
            end else if (step_en) begin
                work_q <= nxt;
            end
            if (last) begin
                for (int l = 0; l < LANES; l++)
                    res_q[l] <= exec_q[l] ? nxt[l] : raw_q[l];
            end
        end
    end

    assign result_o = res_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_WORK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !step_en) |=> $stable(work_q)); // R6
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(op_q)); // R8
endmodule

// File: tb/mscan_seq_tb.sv
module mscan_seq_tb_top;
    localparam int DW  = 8;
    localparam int NL  = 64;
    localparam int LAT = 15;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [1:0]         op = 2'd0;
    logic [NL-1:0]      exec = '0;
    logic [NL*DW-1:0]   din = '0;
    logic               busy, done;
    logic [NL*DW-1:0]   res;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mscan_seq #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .exec_i(exec), .data_i(din), .busy_o(busy), .done_o(done), .result_o(res)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] comb2(logic [1:0] o, logic [DW-1:0] a, logic [DW-1:0] b);
        if (o == 2'd1) return (a < b) ? a : b;
        if (o == 2'd2) return (a > b) ? a : b;
        return a + b;
    endfunction

    // run one job; inj_at >= 0 pulses a spurious start that many cycles after acceptance
    task automatic run_job(input logic [1:0] o, input logic [NL-1:0] m,
                           input logic [NL*DW-1:0] d, input int inj_at);
        logic [DW-1:0]    acc;
        logic [NL*DW-1:0] expv;
        int lat;
        string tag;
        acc = (o == 2'd1) ? '1 : '0;
        for (int l = 0; l < NL; l++) begin
            if (m[l]) begin
                acc = comb2(o, acc, d[l*DW +: DW]);
                expv[l*DW +: DW] = acc;
            end else begin
                expv[l*DW +: DW] = d[l*DW +: DW];
            end
        end
        @(negedge clk);
        start = 1'b1; op = o; exec = m; din = d;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after accept", busy, 1);
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
            if (lat == inj_at) begin
                start = 1'b1; op = ~o; exec = ~m; din = ~d;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(lat == LAT, "R6", "done latency", lat, LAT);
        check(busy == 1'b0, "R7", "busy low with done", busy, 0);
        for (int l = 0; l < NL; l++) begin
            if (!m[l])           tag = "R5";
            else if (m != '1)    tag = "R4";
            else if (o == 2'd1)  tag = "R2";
            else if (o == 2'd2)  tag = "R3";
            else                 tag = "R1";
            check(res[l*DW +: DW] == expv[l*DW +: DW], tag, $sformatf("lane %0d", l),
                  res[l*DW +: DW], expv[l*DW +: DW]);
        end
        @(negedge clk);
        check(done == 1'b0, "R7", "done single cycle", done, 0);
        if (inj_at >= 0) begin
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                check(done == 1'b0 && busy == 1'b0, "R8", "no job from ignored start",
                      {done, busy}, 0);
            end
        end
    endtask

    function automatic logic [NL*DW-1:0] rand_vec();
        logic [NL*DW-1:0] v;
        for (int l = 0; l < NL; l++) v[l*DW +: DW] = DW'($urandom);
        return v;
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NL-1:0]    masks [10];
        logic [NL*DW-1:0] ramp, ones;
        void'($urandom(7));
        masks[0] = '1;
        masks[1] = '0;
        masks[2] = {32{2'b01}};
        masks[3] = 64'h8000_0000_0000_0000;
        masks[4] = 64'h0000_0000_0000_0001;
        masks[5] = 64'h0001_8000_0001_8000;      // lanes at row edges
        masks[6] = 64'hFFFF_0000_FFFF_0000;
        masks[7] = {$urandom, $urandom};
        masks[8] = {$urandom, $urandom} & {$urandom, $urandom};
        masks[9] = {$urandom, $urandom} | {$urandom, $urandom};
        for (int l = 0; l < NL; l++) ramp[l*DW +: DW] = DW'(NL - l);
        ones = '1;

        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R9", "reset flags", {busy, done}, 0);
        check(res == '0, "R9", "reset result", res[63:0], 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int o = 0; o < 4; o++) begin
            for (int mi = 0; mi < 10; mi++) begin
                run_job(2'(o), masks[mi], rand_vec(), -1);
                run_job(2'(o), masks[mi], ramp, -1);
            end
            run_job(2'(o), '1, ones, -1);
        end
        // start pulses during a run are ignored (R8)
        run_job(2'd0, masks[7], rand_vec(), 2);
        run_job(2'd1, masks[9], rand_vec(), 6);
        run_job(2'd2, masks[8], rand_vec(), 14);
        finish_run();
    end
endmodule